// File: doc/BRIEF.md
# Host-Bus Interface Control and Interrupt Registers

This block holds the control and status registers for a host-bus interface that sits beside an embedded processor. A small register port writes and reads two words. The control word holds three things:

- the enables that gate the capture unit's DMA and the processor's role as bus initiator and host;
- the commands that put the processor core and its instruction cache into reset and take them out of it;
- a mode bit that sets which read command DMA transfers use.

The second word collects six event pulses from the bus engine into sticky pending flags. Software clears a flag by writing 1 to it.

The interrupt output is the OR of every pending flag whose enable bit is set in the control word. The core reset output leaves power-on reset asserted. It stays asserted until software writes the release command. The reset output drives only the processor core and the instruction cache. The data cache and the peripherals stay outside it.

Top module: `hbi_csr_top`

## Requirements
- R1: After reset, `core_rst` is 1, `irq` is 0, and the control word (address 0) and the pending word (address 1) both read 0.
- R2: `cap_grant` equals `cap_req` when control bit 0 (capture DMA enable) is 1. It is 0 when that bit is 0.
- R3: `master_en` equals control bit 1 (host enable). `cpu_init_ok` is 1 only when control bit 1 and the `cmd_master_en` input are both 1.
- R4: A write to address 0 with bit 9 set makes `core_rst` 1 from the next cycle. A write with bit 9 at 0 does not assert it.
- R5: A write to address 0 with bit 10 set and bit 9 clear makes `core_rst` 0 from the next cycle. When bits 9 and 10 are both set in one write, the reset is asserted.
- R6: Control bits 0 to 8 read back as written. Bits 9 and 10, and all higher bits, read as 0.
- R7: `rd_cmd` is 4'b1100 (memory read multiple) when `rd_is_dma` is 1 and control bit 8 (read-multiple disable) is 0. Otherwise it is 4'b0110 (memory read).
- R8: A pulse on `evt_pulse[i]` sets pending bit 2+i of address 1, and the bit stays set. The events, in order i = 0 to 5, are:
  - configuration cycle done
  - I/O cycle done
  - DMA cycle done
  - memory write cycle done
  - a second configuration or I/O request
  - a second DMA request
- R9: `irq` is 1 in the cycle after an event pulse when control enable bit 2+i for that event is 1. It stays 0 when that enable bit is 0.
- R10: Writing 1 to a pending bit at address 1 clears it, and writing 0 leaves it unchanged. An event pulse in the same cycle as the clear wins, so the bit stays set.
- R11: Addresses 2 and 3 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed word |
| evt_pulse | input | NUM_EVT | One-cycle event pulses from the bus engine |
| cap_req | input | 1 | Capture unit bus write request |
| cap_grant | output | 1 | Capture request passed to the bus |
| cmd_master_en | input | 1 | Bus-mastering enable from the command register |
| master_en | output | 1 | Host enable, driving mastering enable |
| cpu_init_ok | output | 1 | Processor may initiate bus cycles |
| rd_is_dma | input | 1 | Pending read comes from DMA (1) or the processor (0) |
| rd_cmd | output | 4 | Bus read command to issue |
| core_rst | output | 1 | Reset of processor core and instruction cache |
| irq | output | 1 | Processor interrupt |

## Verification
Every one of the 64 interrupt-enable masks is tried with a pulse on each of the six events in turn. This separates a wrong mapping from event to pending bit, and a wrong enable bit, from a correct OR. Both the gating outputs and the command select are swept over all of their input combinations. The reset commands are driven as set alone, release alone, both together and neither, which exposes a reversed priority or a write of 0 that has an effect. Clear-versus-pulse collisions and the unmapped addresses show that no write touches state it should not.

// File: rtl/hbi_csr_pkg.sv
package hbi_csr_pkg;
   localparam int CB_CAP_EN  = 0;
   localparam int CB_HOST_EN = 1;
   localparam int CB_IEN_LSB = 2;
   localparam int CB_RMD     = 8;
   localparam int CB_RST_SET = 9;
   localparam int CB_RST_CLR = 10;
   localparam int CTRL_W     = 11;
   localparam int MAX_EVT    = CB_RMD - CB_IEN_LSB;

   localparam int RA_CTRL = 0;
   localparam int RA_PEND = 1;

   typedef enum logic [3:0] {
      CMD_MEM_RD      = 4'b0110,
      CMD_MEM_RD_MULT = 4'b1100
   } bus_cmd_e;
endpackage

// File: rtl/hbi_ctl_reg.sv
module hbi_ctl_reg
   import hbi_csr_pkg::*;
#(
   parameter int NUM_EVT = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_ctrl,
   input  logic [CTRL_W-1:0]  wdata,
   output logic               cap_en,
   output logic               host_en,
   output logic [NUM_EVT-1:0] irq_en,
   output logic               rmd,
   output logic               core_rst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en  <= 1'b0;
         host_en <= 1'b0;
         irq_en  <= '0;
         rmd     <= 1'b0;
      end else if (wr_ctrl) begin
         cap_en  <= wdata[CB_CAP_EN];
         host_en <= wdata[CB_HOST_EN];
         irq_en  <= wdata[CB_IEN_LSB +: NUM_EVT];
         rmd     <= wdata[CB_RMD];
      end
   end

   // set command has priority over release when both arrive together
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         core_rst <= 1'b1;
      else if (wr_ctrl && wdata[CB_RST_SET])
         core_rst <= 1'b1;
      else if (wr_ctrl && wdata[CB_RST_CLR])
         core_rst <= 1'b0;
   end
endmodule

// File: rtl/hbi_evt_pend.sv
module hbi_evt_pend #(
   parameter int NUM_EVT = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               clr_we,
   input  logic [NUM_EVT-1:0] clr_mask,
   input  logic [NUM_EVT-1:0] irq_en,
   output logic [NUM_EVT-1:0] pend,
   output logic               irq
);
   logic irq_raw;

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend[g] <= 1'b0;
         else if (evt_pulse[g])
            pend[g] <= 1'b1;
         else if (clr_we && clr_mask[g])
            pend[g] <= 1'b0;
      end
   end

   assign irq_raw = |(pend & irq_en);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end
endmodule

// File: rtl/hbi_cmd_sel.sv
module hbi_cmd_sel
   import hbi_csr_pkg::*;
(
   input  logic       rd_is_dma,
   input  logic       rmd,
   output logic [3:0] rd_cmd
);
   bus_cmd_e cmd;
   always_comb begin
      if (rd_is_dma && !rmd) cmd = CMD_MEM_RD_MULT;
      else                   cmd = CMD_MEM_RD;
   end
   assign rd_cmd = cmd;
endmodule

// File: rtl/hbi_csr_top.sv
module hbi_csr_top
   import hbi_csr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 2,
   parameter int NUM_EVT = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               cap_req,
   output logic               cap_grant,
   input  logic               cmd_master_en,
   output logic               master_en,
   output logic               cpu_init_ok,
   input  logic               rd_is_dma,
   output logic [3:0]         rd_cmd,
   output logic               core_rst,
   output logic               irq
);
   if (DATA_W < CTRL_W) begin : g_chk_dw
      $error("hbi_csr_top: DATA_W too small for control word");
   end
   if (NUM_EVT < 1 || NUM_EVT > MAX_EVT) begin : g_chk_ne
      $error("hbi_csr_top: NUM_EVT out of range");
   end
   if (ADDR_W < 1) begin : g_chk_aw
      $error("hbi_csr_top: ADDR_W must be at least 1");
   end

   logic               cap_en_q, host_en_q, rmd_q;
   logic [NUM_EVT-1:0] irq_en_q, pend_q;
   logic               sel_ctrl, sel_pend;
   logic               unused_wdata;

   assign sel_ctrl = (reg_addr == ADDR_W'(RA_CTRL));
   assign sel_pend = (reg_addr == ADDR_W'(RA_PEND));
   assign unused_wdata = ^reg_wdata[DATA_W-1:CTRL_W];

   hbi_ctl_reg #(.NUM_EVT(NUM_EVT)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (reg_wr && sel_ctrl),
      .wdata    (reg_wdata[CTRL_W-1:0]),
      .cap_en   (cap_en_q),
      .host_en  (host_en_q),
      .irq_en   (irq_en_q),
      .rmd      (rmd_q),
      .core_rst (core_rst)
   );

   hbi_evt_pend #(.NUM_EVT(NUM_EVT), .IRQ_REG(IRQ_REG)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .clr_we    (reg_wr && sel_pend),
      .clr_mask  (reg_wdata[CB_IEN_LSB +: NUM_EVT]),
      .irq_en    (irq_en_q),
      .pend      (pend_q),
      .irq       (irq)
   );

   hbi_cmd_sel u_cmd (
      .rd_is_dma (rd_is_dma),
      .rmd       (rmd_q),
      .rd_cmd    (rd_cmd)
   );

   assign cap_grant   = cap_req && cap_en_q;
   assign master_en   = host_en_q;
   assign cpu_init_ok = host_en_q && cmd_master_en;

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[CB_CAP_EN]               = cap_en_q;
         reg_rdata[CB_HOST_EN]              = host_en_q;
         reg_rdata[CB_IEN_LSB +: NUM_EVT]   = irq_en_q;
         reg_rdata[CB_RMD]                  = rmd_q;
      end else if (sel_pend) begin
         reg_rdata[CB_IEN_LSB +: NUM_EVT]   = pend_q;
      end
   end
endmodule

// File: rtl/hbi_csr_chk.sv
module hbi_csr_chk
   import hbi_csr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 2,
   parameter int NUM_EVT = 6,
   parameter bit IRQ_REG = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_wdata,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic [NUM_EVT-1:0] irq_en_q,
   input logic [NUM_EVT-1:0] pend_q,
   input logic               cap_en_q,
   input logic               cap_grant,
   input logic               rmd_q,
   input logic               rd_is_dma,
   input logic [3:0]         rd_cmd,
   input logic               core_rst,
   input logic               irq
);
   logic wr_ctrl, wr_pend;
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(RA_CTRL));
   assign wr_pend = reg_wr && (reg_addr == ADDR_W'(RA_PEND));

   a_r4_set_asserts: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && reg_wdata[CB_RST_SET] |=> core_rst);

   a_r5_clr_releases: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && reg_wdata[CB_RST_CLR] && !reg_wdata[CB_RST_SET] |=> !core_rst);

   a_r4_no_spurious_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !core_rst && !(wr_ctrl && reg_wdata[CB_RST_SET]) |=> !core_rst);

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((pend_q & $past(evt_pulse)) == $past(evt_pulse)));

   a_r10_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

   a_r9_enabled_event_irq: assert property (@(posedge clk) disable iff (!rst_n || IRQ_REG)
      ((evt_pulse & irq_en_q) != '0) && !wr_ctrl |=> irq);

   always_comb begin
      if (rst_n) begin
         a_r2_gate: assert (cap_en_q || !cap_grant);
         a_r7_cmd: assert (rd_cmd == ((rd_is_dma && !rmd_q) ? 4'b1100 : 4'b0110));
      end
   end
endmodule

bind hbi_csr_top hbi_csr_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .evt_pulse (evt_pulse),
   .irq_en_q  (irq_en_q),
   .pend_q    (pend_q),
   .cap_en_q  (cap_en_q),
   .cap_grant (cap_grant),
   .rmd_q     (rmd_q),
   .rd_is_dma (rd_is_dma),
   .rd_cmd    (rd_cmd),
   .core_rst  (core_rst),
   .irq       (irq)
);

// File: tb/hbi_csr_top_tb_top.sv
module hbi_csr_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 2;
   localparam int NE = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NE-1:0] evt_pulse = '0;
   logic          cap_req = 1'b0, cmd_master_en = 1'b0, rd_is_dma = 1'b0;
   logic          cap_grant, master_en, cpu_init_ok, core_rst, irq;
   logic [3:0]    rd_cmd;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbi_csr_top #(.DATA_W(DW), .ADDR_W(AW), .NUM_EVT(NE)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
      .cap_req(cap_req), .cap_grant(cap_grant), .cmd_master_en(cmd_master_en),
      .master_en(master_en), .cpu_init_ok(cpu_init_ok), .rd_is_dma(rd_is_dma),
      .rd_cmd(rd_cmd), .core_rst(core_rst), .irq(irq));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      reg_addr = AW'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input logic [NE-1:0] p);
      @(negedge clk);
      evt_pulse = p;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 core_rst", DW'(core_rst), 1);
      check("R1 irq", DW'(irq), 0);
      rd(0, v); check("R1 ctrl", v, 0);
      rd(1, v); check("R1 pend", v, 0);

      // R2 capture gating sweep
      for (int e = 0; e < 2; e++) begin
         wr(0, DW'(e));
         for (int r = 0; r < 2; r++) begin
            cap_req = r[0]; #1;
            check("R2 cap_grant", DW'(cap_grant), DW'(e & r));
         end
      end
      cap_req = 1'b0;

      // R3 host enable sweep
      for (int h = 0; h < 2; h++) begin
         wr(0, DW'(h << 1));
         for (int m = 0; m < 2; m++) begin
            cmd_master_en = m[0]; #1;
            check("R3 master_en", DW'(master_en), DW'(h));
            check("R3 cpu_init_ok", DW'(cpu_init_ok), DW'(h & m));
         end
      end

      // R7 read command sweep
      for (int r = 0; r < 2; r++) begin
         wr(0, DW'(r << 8));
         for (int d = 0; d < 2; d++) begin
            rd_is_dma = d[0]; #1;
            check("R7 rd_cmd", DW'(rd_cmd), (d == 1 && r == 0) ? 32'hC : 32'h6);
         end
      end

      // R5 release, R4 set, write of 0 has no effect
      wr(0, 32'h400); check("R5 release", DW'(core_rst), 0);
      wr(0, 32'h000); check("R4 zero write no set", DW'(core_rst), 0);
      wr(0, 32'h200); check("R4 set", DW'(core_rst), 1);
      wr(0, 32'h000); check("R5 zero write no release", DW'(core_rst), 1);
      wr(0, 32'h400); check("R5 release again", DW'(core_rst), 0);
      wr(0, 32'h600); check("R5 both set wins", DW'(core_rst), 1);
      wr(0, 32'h400);

      // R6 readback
      wr(0, 32'hFFFF_F9FF); rd(0, v); check("R6 readback all", v, 32'h1FF);
      check("R6 core_rst untouched", DW'(core_rst), 0);
      wr(0, 32'h0000_0155); rd(0, v); check("R6 readback pattern", v, 32'h155);

      // R8/R9 exhaustive enable mask x event
      for (int m = 0; m < 64; m++) begin
         wr(0, DW'(m << 2));
         for (int i = 0; i < NE; i++) begin
            wr(1, 32'hFC);
            check("R9 irq idle", DW'(irq), 0);
            pulse(NE'(1 << i));
            check("R9 irq", DW'(irq), DW'((m >> i) & 1));
            rd(1, v); check("R8 pend bit", v, DW'(1 << (i + 2)));
         end
      end

      // R10 clear semantics
      wr(0, 32'h0);
      pulse(6'b101101);
      rd(1, v); check("R8 sticky multi", v, 32'hB4);
      wr(1, 32'h0); rd(1, v); check("R10 zero write", v, 32'hB4);
      wr(1, 32'h34); rd(1, v); check("R10 partial clear", v, 32'h80);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'hFC; evt_pulse = 6'b000010;
      @(negedge clk);
      reg_wr = 1'b0; evt_pulse = '0;
      rd(1, v); check("R10 pulse beats clear", v, 32'h08);

      // R11 unmapped addresses
      wr(0, 32'h0000_0003);
      rd(2, v); check("R11 addr2 reads 0", v, 0);
      rd(3, v); check("R11 addr3 reads 0", v, 0);
      wr(3, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
      rd(0, v); check("R11 ctrl unchanged", v, 32'h3);
      rd(1, v); check("R11 pend unchanged", v, 32'h08);
      check("R11 core_rst unchanged", DW'(core_rst), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule